// File: doc/BRIEF.md
# Extended System Instruction Decoder

This unit sits in the execute stage of a small 16-bit pipelined processor. It inspects each issued instruction word and recognises the extended system form. That form is a jump-and-link whose 7-bit immediate is not zero. The immediate is split into a 3-bit operation class in bits [6:4] and a 4-bit data value in bits [3:0].

Each extended instruction produces one of two results, which travel down the pipeline with the instruction:
- An injected exceptional condition for the commit stage, given as a 2-bit category and a 4-bit code.
- A control action for the execute and memory hardware: sleep, halt, panic, a TLB operation, a control-register move, or return from exception.

The unit enforces privilege. Only the trap class may be issued in user mode. For every instruction it also signals whether register accesses go to the control-register bank, which is the case whenever the kernel-mode bit is set.

The result is registered, so it appears one clock after the instruction is accepted.

Top module: `extdec_top`

## Requirements
- R1: An instruction is extended when its opcode field [15:13] is 3'b111 and its immediate [6:0] is non-zero. Any other word, including a jump-and-link with a zero immediate, gives outExc=0 and outAct=0 (none), and passes the rA [12:10] and rB [9:7] fields through unchanged.
- R2: Outputs appear exactly one clock after an accepted instruction. After reset, and in every cycle following one with inValid low, all outputs are zero.
- R3: In kernel mode, class 001 injects category 0 (exception), class 010 injects category 1 (interrupt) and class 011 injects category 2 (trap). In each case the code equals the data value.
- R4: In user mode, class 011 behaves as in R3. Every other extended class, including the reserved one, injects category 0 with code 5 (privilege violation) and performs no action.
- R5: In kernel mode, class 000 (mode) decodes as follows. Data 1 gives action 1 (sleep). Data 2 gives action 2 (halt). Data 8 to 15 give action 3 (panic), with outActArg equal to the data value. Data 3 to 7 inject category 0 with code 3 (invalid opcode).
- R6: In kernel mode, class 100 (TLB) decodes as follows. Data 0 gives action 4 (probe). Data 1 gives action 5 (write). Data 2 gives action 6 (clear). Data 3 to 15 inject invalid opcode.
- R7: In kernel mode, class 101 moves a control register. Data bit 3 set gives action 8 (general register to control register). Data bit 3 clear gives action 7 (control register to general register). In both cases outActArg holds data bits [2:0], the control-register number.
- R8: In kernel mode, class 110 gives action 9 (return from exception), whatever the data value.
- R9: In kernel mode, class 111 (reserved) injects invalid opcode (category 0, code 3).
- R10: For extended instructions, outRegA and outRegB carry the rA and rB fields only for TLB probe, TLB write and return from exception. For every other extended instruction they are zero.
- R11: outCtlBank equals the kernel-mode bit of the accepted instruction, so that ordinary register reads and writes are steered to the control-register bank in kernel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An instruction is presented this cycle |
| inInstr | input | 16 | Instruction word |
| kernelMode | input | 1 | Processor status kernel-mode bit |
| outValid | output | 1 | Decoded result valid |
| outExc | output | 1 | Exceptional condition injected |
| outExcCat | output | 2 | 0 exception, 1 interrupt, 2 trap |
| outExcCode | output | 4 | Condition code within category |
| outAct | output | 4 | Control action (0 none, 1..9 as in requirements) |
| outActArg | output | 4 | Panic value or control-register number |
| outRegA | output | 3 | rA field, or zero when ignored |
| outRegB | output | 3 | rB field, or zero when ignored |
| outCtlBank | output | 1 | Steer register accesses to the control bank |

## Verification
The bench sweeps every 7-bit immediate of the jump-and-link opcode in both privilege modes. This covers all 128 class and data pairs. It separates the valid encodings from the reserved ones, and trapping from privileged behaviour. The rA and rB fields change between vectors, so a decoder that fails to zero the ignored fields, or passes the wrong field, gives a mismatch.

Each of the seven ordinary opcodes is also tried with several field patterns in both modes. These vectors show that only the jump-and-link opcode is decoded, and that the bank steering follows the mode bit. Idle cycles confirm that a result is produced only for an accepted instruction.

// File: rtl/extdec_pkg.sv
package extdec_pkg;
  parameter int OPC_W = 3;
  parameter int IDX_W = 3;
  parameter int CLS_W = 3;
  parameter int DAT_W = 4;
  parameter int CAT_W = 2;
  localparam int IMM_W = CLS_W + DAT_W;
  localparam int INSTR_W = OPC_W + 2 * IDX_W + IMM_W;
  localparam logic [OPC_W-1:0] OPC_JALR = '1;

  typedef enum logic [CLS_W-1:0] {
    CLS_MODE = 3'd0, CLS_EXC = 3'd1, CLS_INT = 3'd2, CLS_TRAP = 3'd3,
    CLS_TLB = 3'd4, CLS_CRMV = 3'd5, CLS_RFE = 3'd6, CLS_RSVD = 3'd7
  } extClass_e;

  typedef enum logic [CAT_W-1:0] {
    CAT_EXC = 2'd0, CAT_INT = 2'd1, CAT_TRAP = 2'd2
  } excCat_e;

  typedef enum logic [DAT_W-1:0] {
    ACT_NONE = 4'd0, ACT_SLEEP = 4'd1, ACT_HALT = 4'd2, ACT_PANIC = 4'd3,
    ACT_TLB_PROBE = 4'd4, ACT_TLB_WRITE = 4'd5, ACT_TLB_CLEAR = 4'd6,
    ACT_CR_TO_GPR = 4'd7, ACT_GPR_TO_CR = 4'd8, ACT_RFE = 4'd9
  } actKind_e;

  localparam logic [DAT_W-1:0] CODE_INVOP = 4'd3;
  localparam logic [DAT_W-1:0] CODE_PRIV = 4'd5;

  typedef struct packed {
    logic inject;
    excCat_e cat;
    logic [DAT_W-1:0] code;
    actKind_e act;
    logic [DAT_W-1:0] arg;
    logic keepRegs;
  } ctlStrobes_t;
endpackage

// File: rtl/extdec_ctrl.sv
module extdec_ctrl
  import extdec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic               kernel,
  output ctlStrobes_t        strobes
);
  localparam int IMM_HI = IMM_W - 1;

  logic [OPC_W-1:0] opc;
  logic [IMM_W-1:0] imm;
  extClass_e        cls;
  logic [DAT_W-1:0] dat;
  logic             isExt;

  assign opc   = instr[INSTR_W-1 -: OPC_W];
  assign imm   = instr[IMM_HI:0];
  assign cls   = extClass_e'(imm[IMM_HI -: CLS_W]);
  assign dat   = imm[DAT_W-1:0];
  assign isExt = (opc == OPC_JALR) && (imm != '0);

  always_comb begin
    strobes = '{inject: 1'b0, cat: CAT_EXC, code: '0, act: ACT_NONE,
                arg: '0, keepRegs: 1'b1};
    if (isExt) begin
      strobes.keepRegs = 1'b0;
      if (!kernel && cls != CLS_TRAP) begin
        strobes.inject = 1'b1;
        strobes.code = CODE_PRIV;
      end else begin
        unique case (cls)
          CLS_MODE: begin
            if (dat[DAT_W-1]) begin
              strobes.act = ACT_PANIC;
              strobes.arg = dat;
            end else if (dat == 4'd1) strobes.act = ACT_SLEEP;
            else if (dat == 4'd2) strobes.act = ACT_HALT;
            else if (dat != 4'd0) begin
              strobes.inject = 1'b1;
              strobes.code = CODE_INVOP;
            end
          end
          CLS_EXC, CLS_INT, CLS_TRAP: begin
            strobes.inject = 1'b1;
            strobes.code = dat;
            strobes.cat = (cls == CLS_EXC) ? CAT_EXC :
                          (cls == CLS_INT) ? CAT_INT : CAT_TRAP;
          end
          CLS_TLB: begin
            if (dat == 4'd0) begin
              strobes.act = ACT_TLB_PROBE;
              strobes.keepRegs = 1'b1;
            end else if (dat == 4'd1) begin
              strobes.act = ACT_TLB_WRITE;
              strobes.keepRegs = 1'b1;
            end else if (dat == 4'd2) strobes.act = ACT_TLB_CLEAR;
            else begin
              strobes.inject = 1'b1;
              strobes.code = CODE_INVOP;
            end
          end
          CLS_CRMV: begin
            strobes.act = dat[DAT_W-1] ? ACT_GPR_TO_CR : ACT_CR_TO_GPR;
            strobes.arg = {1'b0, dat[DAT_W-2:0]};
          end
          CLS_RFE: begin
            strobes.act = ACT_RFE;
            strobes.keepRegs = 1'b1;
          end
          default: begin
            strobes.inject = 1'b1;
            strobes.code = CODE_INVOP;
          end
        endcase
      end
    end
  end

  // R4 / R2: an injected condition never carries an action too
  always_comb begin
    if (strobes.inject) p_inject_excl_r2: assert (strobes.act == ACT_NONE);
  end
endmodule

// File: rtl/extdec_dp.sv
module extdec_dp
  import extdec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instr,
  input  logic               kernel,
  input  ctlStrobes_t        strobes,
  output logic               outValid,
  output logic               outExc,
  output logic [CAT_W-1:0]   outExcCat,
  output logic [DAT_W-1:0]   outExcCode,
  output logic [DAT_W-1:0]   outAct,
  output logic [DAT_W-1:0]   outActArg,
  output logic [IDX_W-1:0]   outRegA,
  output logic [IDX_W-1:0]   outRegB,
  output logic               outCtlBank
);
  localparam int RA_LO = IMM_W + IDX_W;
  localparam int RB_LO = IMM_W;

  logic [IDX_W-1:0] fieldA, fieldB;
  assign fieldA = instr[RA_LO +: IDX_W];
  assign fieldB = instr[RB_LO +: IDX_W];

  always_ff @(posedge clk) begin
    if (!rstN || !inValid) begin
      outValid   <= 1'b0;
      outExc     <= 1'b0;
      outExcCat  <= '0;
      outExcCode <= '0;
      outAct     <= '0;
      outActArg  <= '0;
      outRegA    <= '0;
      outRegB    <= '0;
      outCtlBank <= 1'b0;
    end else begin
      outValid   <= 1'b1;
      outExc     <= strobes.inject;
      outExcCat  <= strobes.cat;
      outExcCode <= strobes.code;
      outAct     <= strobes.act;
      outActArg  <= strobes.arg;
      outRegA    <= strobes.keepRegs ? fieldA : '0;
      outRegB    <= strobes.keepRegs ? fieldB : '0;
      outCtlBank <= kernel;
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outExc && outAct == '0 && !outCtlBank && outRegA == '0));
  p_user_only_trap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outCtlBank && outExc) |->
      (outExcCat == CAT_TRAP || (outExcCat == CAT_EXC && outExcCode == CODE_PRIV)));
  p_user_no_action_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outCtlBank) |-> outAct == ACT_NONE);
  p_panic_arg_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outAct == ACT_PANIC) |-> outActArg[DAT_W-1]);
  p_exc_regs_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    outExc |-> (outRegA == '0 && outRegB == '0 && outActArg == '0));
endmodule

// File: rtl/extdec_top.sv
module extdec_top
  import extdec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [15:0] inInstr,
  input  logic        kernelMode,
  output logic        outValid,
  output logic        outExc,
  output logic [1:0]  outExcCat,
  output logic [3:0]  outExcCode,
  output logic [3:0]  outAct,
  output logic [3:0]  outActArg,
  output logic [2:0]  outRegA,
  output logic [2:0]  outRegB,
  output logic        outCtlBank
);
  ctlStrobes_t strobes;

  extdec_ctrl u_ctrl (
    .instr(inInstr), .kernel(kernelMode), .strobes(strobes)
  );

  extdec_dp u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(inInstr),
    .kernel(kernelMode), .strobes(strobes),
    .outValid(outValid), .outExc(outExc), .outExcCat(outExcCat),
    .outExcCode(outExcCode), .outAct(outAct), .outActArg(outActArg),
    .outRegA(outRegA), .outRegB(outRegB), .outCtlBank(outCtlBank)
  );
endmodule

// File: tb/tb_extdec_top.sv
`timescale 1ns/1ps
module tb_extdec_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [15:0] inInstr = '0;
  logic kernelMode = 1'b0;
  logic outValid, outExc, outCtlBank;
  logic [1:0] outExcCat;
  logic [3:0] outExcCode, outAct, outActArg;
  logic [2:0] outRegA, outRegB;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  extdec_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inInstr(inInstr),
    .kernelMode(kernelMode), .outValid(outValid), .outExc(outExc),
    .outExcCat(outExcCat), .outExcCode(outExcCode), .outAct(outAct),
    .outActArg(outActArg), .outRegA(outRegA), .outRegB(outRegB),
    .outCtlBank(outCtlBank)
  );

  // expected word layout: {valid, exc, cat[1:0], code[3:0], act[3:0], arg[3:0], ra[2:0], rb[2:0], bank}
  function automatic logic [24:0] pack(logic v, logic e, logic [1:0] c, logic [3:0] cd,
                                       logic [3:0] a, logic [3:0] g, logic [2:0] ra,
                                       logic [2:0] rb, logic bk);
    return {v, e, c, cd, a, g, ra, rb, bk};
  endfunction

  function automatic logic [24:0] observed();
    return pack(outValid, outExc, outExcCat, outExcCode, outAct, outActArg,
                outRegA, outRegB, outCtlBank);
  endfunction

  task automatic check(string req, logic [24:0] exp);
    checks++;
    if (observed() !== exp) begin
      failures++;
      $display("FAIL %s instr=%h k=%0b got=%h exp=%h", req, inInstr, kernelMode,
               observed(), exp);
    end
  endtask

  // Model built from the requirement text
  task automatic expect_for(input int op, input int ra, input int rb, input int imm,
                            input bit k, output logic [24:0] exp, output string req);
    int cls = imm / 16;
    int dat = imm % 16;
    int keep = 0;
    int e = 0, cat = 0, code = 0, act = 0, arg = 0;
    if (op != 7 || imm == 0) begin
      req = "R1"; keep = 1;
    end else if (!k && cls != 3) begin
      req = "R4"; e = 1; code = 5;
    end else if (cls >= 1 && cls <= 3) begin
      req = (cls == 3 && !k) ? "R4" : "R3"; e = 1; cat = cls - 1; code = dat;
    end else if (cls == 0) begin
      req = "R5";
      if (dat >= 8) begin act = 3; arg = dat; end
      else if (dat == 1 || dat == 2) act = dat;
      else begin e = 1; code = 3; end
    end else if (cls == 4) begin
      req = "R6";
      if (dat <= 2) begin act = 4 + dat; keep = (dat < 2) ? 1 : 0; end
      else begin e = 1; code = 3; end
    end else if (cls == 5) begin
      req = "R7"; act = (dat >= 8) ? 8 : 7; arg = dat % 8;
    end else if (cls == 6) begin
      req = "R8"; act = 9; keep = 1;
    end else begin
      req = "R9"; e = 1; code = 3;
    end
    exp = pack(1'b1, e[0], cat[1:0], code[3:0], act[3:0], arg[3:0],
               keep ? ra[2:0] : 3'd0, keep ? rb[2:0] : 3'd0, k);
  endtask

  task automatic run_one(input int op, input int ra, input int rb, input int imm, input bit k);
    logic [24:0] exp;
    string req;
    inValid = 1'b1;
    kernelMode = k;
    inInstr = {op[2:0], ra[2:0], rb[2:0], imm[6:0]};
    expect_for(op, ra, rb, imm, k, exp, req);
    @(posedge clk); #1;
    check(req, exp);
    if (req != "R1" && !exp[17] && !(k == 1'b0))
      ; // action results already compared in full (R10, R11 fields included)
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset", '0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R2 idle", '0);

    // R3..R10: every immediate, both modes, varying register fields
    for (int k = 0; k < 2; k++) begin
      for (int imm = 0; imm < 128; imm++) begin
        run_one(7, (imm * 3 + 1) % 8, (imm * 5 + 2 + k) % 8, imm, k[0]);
      end
    end

    // R1, R11: ordinary opcodes are not decoded, bank follows mode
    for (int k = 0; k < 2; k++)
      for (int op = 0; op < 7; op++)
        for (int p = 0; p < 6; p++)
          run_one(op, (p + op) % 8, (7 - p) % 8, (p * 37 + op * 11) % 128, k[0]);

    // R2: after an idle cycle outputs return to zero, even in kernel mode
    kernelMode = 1'b1;
    inInstr = 16'hE07F;
    inValid = 1'b0;
    @(posedge clk); #1;
    check("R2 drop", '0);

    // R11 / R10 corner: rfe in kernel with all-ones fields
    run_one(7, 7, 7, 7'h6F, 1'b1);
    // R4: reserved class in user mode is a privilege violation
    run_one(7, 5, 6, 7'h7F, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule